// File: doc/BRIEF.md
# Hashed Global-History Branch Predictor

This block predicts branches for a fetch stage. In every cycle it takes an instruction address, a branch kind and a signed offset that decode may already know. In the same cycle it returns a predicted direction and a predicted target. The direction comes from a table of saturating counters. The table is indexed by the low address bits XORed with a global history register. The target normally comes from the same table entry. When decode supplies a non-zero offset, the target is the branch address plus that offset instead. An offset of zero means that no offset is known.

A small circular return-address stack serves calls and returns. A call pushes the address of the next instruction. A return pops the stack and uses the popped value as its target. A separate update port carries the resolved outcome of a branch. Each update trains the indexed counter, overwrites the stored target and shifts the outcome into the global history.

Top module: `bp_hashed_predictor`

## Requirements
- R1: After reset every counter holds the weakly-not-taken value (2^(CNT_W-1))-1, every stored target is 0, the history is 0 and the return stack is empty.
- R2: Both the prediction and the update index are addr[IDX_W-1:0] XOR the zero-extended history. The update uses the history value from before its own shift. Two addresses that differ only above bit IDX_W-1 therefore share an entry.
- R3: Kind codes are 0 none, 1 conditional, 2 loop-closing, 3 unconditional, 4 call and 5 return. Kinds 0, 1 and 2 predict taken exactly when the counter MSB is set. Kinds 3, 4 and 5 always predict taken.
- R4: When the offset input is non-zero, the target is addr plus the offset, read as two's complement modulo 2^ADDR_W. When the offset is zero, the target is the stored target of the indexed entry.
- R5: On update the indexed counter increments when taken and decrements when not taken. It saturates at 2^CNT_W-1 and at 0.
- R6: On update the stored target of the indexed entry is overwritten with the resolved target, whatever the outcome.
- R7: On update the history shifts left by one bit. The outcome (1 for taken) enters at bit 0 and only HIST_W bits are kept.
- R8: A valid call pushes addr+4. When the stack already holds RAS_DEPTH entries, the oldest entry is lost.
- R9: A valid return with a non-empty stack predicts the most recent pushed value and pops it. A return on an empty stack leaves the stack empty and follows the R4 rule.
- R10: With pred_valid low, the return stack is neither pushed nor popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_valid | input | 1 | Lookup is real; enables stack push and pop |
| pred_addr | input | ADDR_W | Address of the branch being predicted |
| pred_kind | input | 3 | Branch kind code (see R3) |
| pred_offset | input | ADDR_W | Signed offset known at decode, 0 when unknown |
| pred_taken | output | 1 | Predicted direction |
| pred_target | output | ADDR_W | Predicted target address |
| upd_valid | input | 1 | Resolved outcome present |
| upd_addr | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction |
| upd_target | input | ADDR_W | Resolved target address |

## Verification
The bench drives counters into both saturation limits. A design that wraps instead of saturating would flip its direction after one opposite outcome. It aliases two addresses that differ only above the index bits, and it checks that the update index uses the history from before the shift; an off-by-one-cycle history would train the wrong entry. It overflows the return stack with six calls and then underflows it, which exposes stacks that drop the newest entry or return stale data when empty. Offsets of zero and negative offsets separate the table target from the offset-based target.

// File: rtl/bp_pkg.sv
package bp_pkg;
    typedef enum logic [2:0] {
        BK_NONE   = 3'd0,
        BK_COND   = 3'd1,
        BK_LOOP   = 3'd2,
        BK_UNCOND = 3'd3,
        BK_CALL   = 3'd4,
        BK_RET    = 3'd5
    } br_kind_e;
endpackage

// File: rtl/bp_counter_table.sv
module bp_counter_table #(
    parameter int CNT_W  = 2,
    parameter int IDX_W  = 11,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [CNT_W-1:0]  rd_cnt,
    output logic [ADDR_W-1:0] rd_tgt,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_taken,
    input  logic [ADDR_W-1:0] wr_tgt
);
    localparam int ENTRIES = 1 << IDX_W;
    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'((1 << (CNT_W - 1)) - 1);

    typedef struct packed {
        logic              we;
        logic [IDX_W-1:0]  idx;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] tgt;
    } wr_req_t;

    logic [CNT_W-1:0]  cnt_q [ENTRIES];
    logic [ADDR_W-1:0] tgt_q [ENTRIES];
    wr_req_t           wr_d;
    logic [CNT_W-1:0]  cur_cnt;

    assign rd_cnt  = cnt_q[rd_idx];
    assign rd_tgt  = tgt_q[rd_idx];
    assign cur_cnt = cnt_q[wr_idx];

    always_comb begin
        wr_d.we  = wr_en;
        wr_d.idx = wr_idx;
        wr_d.tgt = wr_tgt;
        if (wr_taken) begin
            wr_d.cnt = (cur_cnt == CNT_MAX) ? cur_cnt : cur_cnt + 1'b1;
        end else begin
            wr_d.cnt = (cur_cnt == '0) ? cur_cnt : cur_cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                cnt_q[i] <= CNT_INIT;
                tgt_q[i] <= '0;
            end
        end else if (wr_d.we) begin
            cnt_q[wr_d.idx] <= wr_d.cnt;
            tgt_q[wr_d.idx] <= wr_d.tgt;
        end
    end

    AST_CNT_SAT_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_taken && cur_cnt == CNT_MAX) |=> (cnt_q[$past(wr_idx)] == CNT_MAX)); // R5
    AST_CNT_SAT_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_taken && cur_cnt == '0) |=> (cnt_q[$past(wr_idx)] == '0)); // R5
    AST_TGT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (tgt_q[$past(wr_idx)] == $past(wr_tgt))); // R6
endmodule

// File: rtl/bp_history.sv
module bp_history #(
    parameter int HIST_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              taken_in,
    output logic [HIST_W-1:0] hist
);
    logic [HIST_W-1:0] hist_d, hist_q;

    always_comb begin
        hist_d = hist_q;
        if (shift_en) begin
            hist_d = {hist_q[HIST_W-2:0], taken_in};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= hist_d;
    end

    assign hist = hist_q;

    AST_HIST_LSB: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (hist_q[0] == $past(taken_in))); // R7
    AST_HIST_AGE: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (hist_q[HIST_W-1:1] == $past(hist_q[HIST_W-2:0]))); // R7
    AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(hist_q)); // R7
endmodule

// File: rtl/bp_ret_stack.sv
module bp_ret_stack #(
    parameter int DEPTH  = 5,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [ADDR_W-1:0] push_addr,
    output logic [ADDR_W-1:0] top,
    output logic              nonempty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int OCC_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [OCC_W-1:0] OCC_FULL = OCC_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][ADDR_W-1:0] ent;
        logic [PTR_W-1:0]             wptr;
        logic [OCC_W-1:0]             occ;
    } ras_t;

    ras_t s_d, s_q;
    logic [PTR_W-1:0] prev_ptr;

    assign prev_ptr = (s_q.wptr == '0) ? PTR_LAST : s_q.wptr - 1'b1;
    assign top      = s_q.ent[prev_ptr];
    assign nonempty = (s_q.occ != '0);

    always_comb begin
        s_d = s_q;
        if (push) begin
            s_d.ent[s_q.wptr] = push_addr;
            s_d.wptr = (s_q.wptr == PTR_LAST) ? '0 : s_q.wptr + 1'b1;
            s_d.occ  = (s_q.occ == OCC_FULL) ? s_q.occ : s_q.occ + 1'b1;
        end else if (pop && nonempty) begin
            s_d.wptr = prev_ptr;
            s_d.occ  = s_q.occ - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_RAS_PUSH_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (nonempty && top == $past(push_addr))); // R8
    AST_RAS_POP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && nonempty) |=> (s_q.occ == $past(s_q.occ) - 1'b1)); // R9
    AST_RAS_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !nonempty) |=> !nonempty); // R9
    AST_RAS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.occ <= OCC_FULL); // R8
endmodule

// File: rtl/bp_hashed_predictor.sv
module bp_hashed_predictor #(
    parameter int ADDR_W    = 32,
    parameter int CNT_W     = 2,
    parameter int IDX_W     = 11,
    parameter int HIST_W    = 10,
    parameter int RAS_DEPTH = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pred_valid,
    input  logic [ADDR_W-1:0] pred_addr,
    input  logic [2:0]        pred_kind,
    input  logic [ADDR_W-1:0] pred_offset,
    output logic              pred_taken,
    output logic [ADDR_W-1:0] pred_target,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic              upd_taken,
    input  logic [ADDR_W-1:0] upd_target
);
    import bp_pkg::*;

    logic [HIST_W-1:0] hist;
    logic [IDX_W-1:0]  rd_idx, wr_idx;
    logic [CNT_W-1:0]  rd_cnt;
    logic [ADDR_W-1:0] rd_tgt, ras_top;
    logic              ras_nonempty, ras_push, ras_pop, forced;
    br_kind_e          kind;

    assign kind   = br_kind_e'(pred_kind);
    assign rd_idx = pred_addr[IDX_W-1:0] ^ IDX_W'(hist);
    assign wr_idx = upd_addr[IDX_W-1:0] ^ IDX_W'(hist);

    always_comb begin
        forced   = (kind == BK_UNCOND) || (kind == BK_CALL) || (kind == BK_RET);
        ras_push = pred_valid && (kind == BK_CALL);
        ras_pop  = pred_valid && (kind == BK_RET);
        pred_taken = forced || rd_cnt[CNT_W-1];
        if ((kind == BK_RET) && ras_nonempty) begin
            pred_target = ras_top;
        end else if (pred_offset != '0) begin
            pred_target = pred_addr + pred_offset;
        end else begin
            pred_target = rd_tgt;
        end
    end

    bp_counter_table #(.CNT_W(CNT_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(rd_idx), .rd_cnt(rd_cnt), .rd_tgt(rd_tgt),
        .wr_en(upd_valid), .wr_idx(wr_idx), .wr_taken(upd_taken), .wr_tgt(upd_target)
    );

    bp_history #(.HIST_W(HIST_W)) u_hist (
        .clk(clk), .rst_n(rst_n),
        .shift_en(upd_valid), .taken_in(upd_taken), .hist(hist)
    );

    bp_ret_stack #(.DEPTH(RAS_DEPTH), .ADDR_W(ADDR_W)) u_ras (
        .clk(clk), .rst_n(rst_n),
        .push(ras_push), .pop(ras_pop), .push_addr(pred_addr + ADDR_W'(4)),
        .top(ras_top), .nonempty(ras_nonempty)
    );

    AST_FORCED_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_kind == 3'd3 || pred_kind == 3'd4 || pred_kind == 3'd5) |-> pred_taken); // R3
    AST_OFFSET_TGT: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_offset != '0 && !(pred_kind == 3'd5 && ras_nonempty))
            |-> (pred_target == pred_addr + pred_offset)); // R4
    AST_IDLE_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_valid |=> ($stable(ras_nonempty) && $stable(ras_top))); // R10
endmodule

// File: tb/bp_hashed_predictor_tb.sv
module bp_hashed_predictor_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ENTRIES = 2048;
    localparam int DEPTH = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pred_valid = 1'b0;
    logic [31:0] pred_addr = '0;
    logic [2:0]  pred_kind = '0;
    logic [31:0] pred_offset = '0;
    logic        pred_taken;
    logic [31:0] pred_target;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_addr = '0;
    logic        upd_taken = 1'b0;
    logic [31:0] upd_target = '0;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    int          m_cnt [ENTRIES];
    logic [31:0] m_tgt [ENTRIES];
    int          m_hist;
    logic [31:0] m_ras [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    bp_hashed_predictor u_dut (
        .clk(clk), .rst_n(rst_n),
        .pred_valid(pred_valid), .pred_addr(pred_addr), .pred_kind(pred_kind),
        .pred_offset(pred_offset), .pred_taken(pred_taken), .pred_target(pred_target),
        .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_taken(upd_taken),
        .upd_target(upd_target)
    );

    task automatic step(input bit pv, input logic [31:0] pa, input int pk,
                        input logic [31:0] po, input bit uv, input logic [31:0] ua,
                        input bit ut, input logic [31:0] utg, input string tag);
        int idx, uidx;
        bit exp_taken;
        logic [31:0] exp_tgt;
        @(negedge clk);
        pred_valid = pv; pred_addr = pa; pred_kind = 3'(pk); pred_offset = po;
        upd_valid = uv; upd_addr = ua; upd_taken = ut; upd_target = utg;
        #1;
        idx = int'(pa[10:0]) ^ m_hist;
        exp_taken = (pk >= 3 && pk <= 5) ? 1'b1 : (m_cnt[idx] >= 2);
        if (pk == 5 && m_ras.size() > 0) exp_tgt = m_ras[m_ras.size()-1];
        else if (po != 0)                exp_tgt = pa + po;
        else                             exp_tgt = m_tgt[idx];
        vectors++;
        if (pred_taken !== exp_taken || pred_target !== exp_tgt) begin
            miscompares++;
            $display("FAIL %s: taken/target actual %0b/%h expected %0b/%h",
                     tag, pred_taken, pred_target, exp_taken, exp_tgt);
        end
        @(posedge clk);
        if (pv && pk == 4) begin
            if (m_ras.size() == DEPTH) void'(m_ras.pop_front());
            m_ras.push_back(pa + 32'd4);
        end else if (pv && pk == 5 && m_ras.size() > 0) begin
            void'(m_ras.pop_back());
        end
        if (uv) begin
            uidx = int'(ua[10:0]) ^ m_hist;
            if (ut) m_cnt[uidx] = (m_cnt[uidx] == 3) ? 3 : m_cnt[uidx] + 1;
            else    m_cnt[uidx] = (m_cnt[uidx] == 0) ? 0 : m_cnt[uidx] - 1;
            m_tgt[uidx] = utg;
            m_hist = ((m_hist << 1) | int'(ut)) & 32'h3FF;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < ENTRIES; i++) begin m_cnt[i] = 1; m_tgt[i] = '0; end
        m_hist = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset state, weakly not taken with zero target
        step(1, 32'h100, 1, 0, 0, 0, 0, 0, "R1");
        step(0, 32'h7FC, 2, 0, 0, 0, 0, 0, "R1");

        // R5 R6 R7: train one address taken until history is all ones
        for (int i = 0; i < 12; i++) step(0, 0, 0, 0, 1, 32'h40, 1, 32'h2000, "R5");
        step(1, 32'h40, 1, 0, 0, 0, 0, 0, "R6");
        // R5: saturated high, one not-taken stays taken
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1, 32'h40, 1, 32'h2000, "R5");
        step(1, 32'h40, 1, 0, 1, 32'h40, 0, 32'h2100, "R7");
        step(1, 32'h40, 1, 0, 0, 0, 0, 0, "R5");
        // R2: alias across bit 11 shares the entry
        step(1, 32'h840, 1, 0, 0, 0, 0, 0, "R2");
        // R5: drive low to zero saturation
        for (int i = 0; i < 14; i++) step(0, 0, 0, 0, 1, 32'h80, 0, 32'h3000, "R5");
        step(1, 32'h80, 2, 0, 1, 32'h80, 1, 32'h3000, "R5");
        step(1, 32'h80, 1, 0, 0, 0, 0, 0, "R2");
        // R4: negative and positive known offsets, zero offset uses table
        step(1, 32'h1000, 1, 32'hFFFF_FFF0, 0, 0, 0, 0, "R4");
        step(1, 32'h1000, 3, 32'h0000_0100, 0, 0, 0, 0, "R4");
        step(1, 32'h80, 3, 0, 0, 0, 0, 0, "R3");
        // R8: six calls overflow a five-deep stack
        for (int i = 0; i < 6; i++) step(1, 32'h5000 + 32'(i*16), 4, 32'h40, 0, 0, 0, 0, "R8");
        // R10: idle call and return leave the stack alone
        step(0, 32'h9000, 4, 0, 0, 0, 0, 0, "R10");
        step(0, 32'h9000, 5, 0, 0, 0, 0, 0, "R10");
        // R9: pop five, then empty returns follow table/offset rule
        for (int i = 0; i < 6; i++) step(1, 32'h6000, 5, 0, 0, 0, 0, 0, "R9");
        step(1, 32'h6000, 5, 32'h20, 0, 0, 0, 0, "R9");

        // Mixed traffic with aliasing addresses
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] a, o, ua, ut;
            a  = 32'($urandom_range(0, 1023)) << 2;
            o  = ($urandom_range(0, 1) == 1) ? 32'($signed($urandom_range(0, 255)) - 128) : 32'd0;
            ua = 32'($urandom_range(0, 1023)) << 2;
            ut = 32'($urandom);
            step($urandom_range(0, 1) == 1, a, int'($urandom_range(0, 5)), o,
                 $urandom_range(0, 1) == 1, ua, $urandom_range(0, 1) == 1, ut, "R3");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule